// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the serial bit clock and the left/right frame clocks that an audio serial port needs, together with single-cycle strobes that tell a serializer when to launch or capture a bit. All logic runs on the master clock. In master mode an integer divider turns the master clock into the bit clock. Two further dividers, one for transmit and one for receive, count bit periods to form the frame clocks. In slave mode the block resynchronises bit and frame clocks supplied from outside and derives the same strobes from their edges.

Plain configuration inputs select the mode, the launch edge, the bit divider and the two frame lengths. A sharing bit lets the receive side take the transmit frame clock. A new divider value is applied only at a frame boundary, so no bit or frame pulse already in progress is shortened. The bit clock rate is normally 64 times the sample rate: two 32-bit slots per frame with a frame length field of 63. The bit divider must divide the master clock exactly.

Top module: `aud_sclk_gen`

## Requirements
- R1: In master mode the bit clock period is `cfg_bdiv`+1 master cycles, with a minimum of 2 (values 0 and 1 both give 2). The clock is high for the upper half of the ratio, rounded up, and low for the rest, so an odd ratio is high one cycle longer.
- R2: When `cfg_launch_rise`=0, `tx_shift_stb` marks falling bit-clock edges and `rx_sample_stb` marks rising ones. When it is 1 the two are swapped. The two strobes are never high together.
- R3: Each strobe is high for exactly one master cycle: the first cycle in which `bclk_o` shows its new level.
- R4: A frame lasts `cfg_tx_len`+1 launch strobes, with a minimum of 2. The frame clock is low (left slot) for half of those, rounded down, and high for the rest. It changes one master cycle after the launch strobe that moves it.
- R5: `tx_frame_stb` is a one-cycle pulse in the first cycle the transmit frame clock is low. That cycle directly follows a launch strobe.
- R6: The receive frame divider runs from the same launch strobes, with its own length `cfg_rx_len`, independently of the transmit length.
- R7: With `cfg_rx_share`=1, `rx_fclk_o` and `rx_frame_stb` equal `tx_fclk_o` and `tx_frame_stb` in every cycle.
- R8: A new frame length takes effect only at the next frame boundary of that side. The frame running when it is written completes with the old length.
- R9: A new bit divider value takes effect at the first rising bit-clock edge after a transmit frame boundary. Bit periods before that use the old value.
- R10: With `cfg_master`=0, `bclk_o`, `tx_fclk_o` and `rx_fclk_o` follow `ext_bclk`, `ext_tx_fclk` and `ext_rx_fclk` delayed by two master cycles. Launch and capture strobes follow the edges of the resynchronised bit clock, and frame strobes follow the falling edges of the resynchronised frame clocks.
- R11: While `rst_n` is low, all clock outputs and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_launch_rise | input | 1 | 1: data launched on rising bit-clock edge |
| cfg_bdiv | input | BDIV_W | Bit divider ratio minus one |
| cfg_tx_len | input | FLEN_W | Transmit frame length in bits minus one |
| cfg_rx_len | input | FLEN_W | Receive frame length in bits minus one |
| cfg_rx_share | input | 1 | Receive side uses transmit frame clock |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_tx_fclk | input | 1 | External transmit frame clock (slave mode) |
| ext_rx_fclk | input | 1 | External receive frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock |
| tx_fclk_o | output | 1 | Transmit frame clock |
| rx_fclk_o | output | 1 | Receive frame clock |
| tx_shift_stb | output | 1 | Launch strobe for the transmit serializer |
| tx_frame_stb | output | 1 | Start of transmit frame |
| rx_sample_stb | output | 1 | Capture strobe for the receive deserializer |
| rx_frame_stb | output | 1 | Start of receive frame |

## Verification
The bench measures bit periods for both an even and an odd ratio. A divider with the wrong rounding would give a symmetric odd clock or an off-by-one period. It writes a new divider value and a new frame length in the middle of a frame and checks that the frame in progress keeps the old value. A design that reloads at once would shorten that frame or split a bit period. It swaps the launch edge, turns on clock sharing and switches to slave mode. A mistake in any of these shows up as strobes on the wrong edge, receive frame clocks that differ from transmit, or external clocks that arrive with the wrong delay.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;

  // Which bit-clock edge launches serial data.
  typedef enum logic {
    LAUNCH_ON_FALL = 1'b0,
    LAUNCH_ON_RISE = 1'b1
  } launch_e;

  // One bit clock with its edge markers, all in the master clock domain.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } bitclk_t;

  function automatic logic launch_of(input launch_e sel, input bitclk_t b);
    return (sel == LAUNCH_ON_RISE) ? b.rise : b.fall;
  endfunction

  function automatic logic capture_of(input launch_e sel, input bitclk_t b);
    return (sel == LAUNCH_ON_RISE) ? b.fall : b.rise;
  endfunction

endpackage

// File: rtl/aud_sclk_bitdiv.sv
module aud_sclk_bitdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_div,
  input  logic          reload_req,
  output logic          bclk,
  output logic          rise_stb,
  output logic          fall_stb
);
  localparam int CW = DW + 1;

  logic [CW-1:0] ratio_q, cnt_q, hi_len, want_ratio, cnt_inc;
  logic          pend_q, wrap;

  always_comb begin
    want_ratio = (cfg_div <= DW'(1)) ? CW'(2) : (CW'(cfg_div) + CW'(1));
    hi_len     = (ratio_q + CW'(1)) >> 1;
    cnt_inc    = cnt_q + CW'(1);
    wrap       = (cnt_inc == ratio_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= CW'(2);
      cnt_q    <= CW'(1);
      bclk     <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (wrap) begin
        cnt_q    <= '0;
        bclk     <= 1'b1;
        rise_stb <= 1'b1;
        pend_q   <= 1'b0;
        if (pend_q || reload_req) ratio_q <= want_ratio;
      end else begin
        cnt_q  <= cnt_inc;
        pend_q <= pend_q | reload_req;
        if (cnt_inc == hi_len) begin
          bclk     <= 1'b0;
          fall_stb <= 1'b1;
        end
      end
    end
  end

  // R3: rise marker only in the first cycle of a high level
  p_rise_marks_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (bclk && !$past(bclk)));
  // R3: fall marker only in the first cycle of a low level
  p_fall_marks_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!bclk && $past(bclk)));
  // R2: the two edges are never marked together
  p_edges_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
  // R9: the ratio changes only on a rising edge
  p_ratio_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> rise_stb);
  // R1: the level never changes without its marker
  p_level_has_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != $past(bclk)) |-> (rise_stb || fall_stb));

endmodule

// File: rtl/aud_sclk_framediv.sv
module aud_sclk_framediv #(
  parameter int FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [FW-1:0] cfg_len,
  output logic          fclk,
  output logic          frame_stb
);
  localparam int SW = FW + 1;

  logic [SW-1:0] span_q, cnt_q, half, want_span, cnt_inc;
  logic          at_end;

  always_comb begin
    want_span = (cfg_len <= FW'(1)) ? SW'(2) : (SW'(cfg_len) + SW'(1));
    half      = span_q >> 1;
    cnt_inc   = cnt_q + SW'(1);
    at_end    = (cnt_inc == span_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q    <= SW'(2);
      cnt_q     <= '0;
      fclk      <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      frame_stb <= 1'b0;
      if (step) begin
        if (at_end) begin
          cnt_q     <= '0;
          fclk      <= 1'b0;
          frame_stb <= 1'b1;
          span_q    <= want_span;
        end else begin
          cnt_q <= cnt_inc;
          fclk  <= (cnt_inc >= half);
        end
      end
    end
  end

  // R5: frame strobe sits on the falling frame edge
  p_stb_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (!fclk && $past(fclk)));
  // R5: frame strobe follows a launch strobe
  p_stb_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> $past(step));
  // R8: the length is replaced only at a boundary
  p_span_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(span_q) |-> frame_stb);
  // R4: the frame clock moves only after a launch strobe
  p_fclk_moves_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk != $past(fclk)) |-> $past(step));

endmodule

// File: rtl/aud_sclk_sync.sv
module aud_sclk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= '0;
      else        st[i] <= st[i-1];
    end
  end

  assign q      = st[STAGES-1];
  assign q_prev = st[STAGES];

  // R10: the output level is the previous stage one cycle late
  p_chain_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_prev == $past(q));

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
  import aud_sclk_pkg::*;
#(
  parameter int BDIV_W      = 8,
  parameter int FLEN_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_launch_rise,
  input  logic [BDIV_W-1:0] cfg_bdiv,
  input  logic [FLEN_W-1:0] cfg_tx_len,
  input  logic [FLEN_W-1:0] cfg_rx_len,
  input  logic              cfg_rx_share,
  input  logic              ext_bclk,
  input  logic              ext_tx_fclk,
  input  logic              ext_rx_fclk,
  output logic              bclk_o,
  output logic              tx_fclk_o,
  output logic              rx_fclk_o,
  output logic              tx_shift_stb,
  output logic              tx_frame_stb,
  output logic              rx_sample_stb,
  output logic              rx_frame_stb
);
  localparam int EXT_W = 3;

  launch_e sel;
  bitclk_t gen_b, ext_b, cur_b;
  logic    gen_launch;
  logic    g_tx_f, g_tx_s, g_rx_f, g_rx_s;
  logic [EXT_W-1:0] ext_q, ext_p;
  logic    e_tx_f, e_tx_s, e_rx_f, e_rx_s;
  logic    own_rx_f, own_rx_s;

  assign sel = launch_e'(cfg_launch_rise);

  // Generated bit clock
  aud_sclk_bitdiv #(.DW(BDIV_W)) u_bitdiv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_div    (cfg_bdiv),
    .reload_req (g_tx_s),
    .bclk       (gen_b.level),
    .rise_stb   (gen_b.rise),
    .fall_stb   (gen_b.fall)
  );

  assign gen_launch = launch_of(sel, gen_b);

  // Generated frame clocks, one per direction
  aud_sclk_framediv #(.FW(FLEN_W)) u_tx_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (gen_launch),
    .cfg_len   (cfg_tx_len),
    .fclk      (g_tx_f),
    .frame_stb (g_tx_s)
  );

  aud_sclk_framediv #(.FW(FLEN_W)) u_rx_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (gen_launch),
    .cfg_len   (cfg_rx_len),
    .fclk      (g_rx_f),
    .frame_stb (g_rx_s)
  );

  // External clocks brought into the master clock domain
  aud_sclk_sync #(.W(EXT_W), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({ext_rx_fclk, ext_tx_fclk, ext_bclk}),
    .q      (ext_q),
    .q_prev (ext_p)
  );

  always_comb begin
    ext_b.level = ext_q[0];
    ext_b.rise  = ext_q[0] & ~ext_p[0];
    ext_b.fall  = ~ext_q[0] & ext_p[0];
    e_tx_f      = ext_q[1];
    e_tx_s      = ~ext_q[1] & ext_p[1];
    e_rx_f      = ext_q[2];
    e_rx_s      = ~ext_q[2] & ext_p[2];
  end

  // Output selection
  always_comb begin
    cur_b         = cfg_master ? gen_b : ext_b;
    bclk_o        = cur_b.level;
    tx_shift_stb  = launch_of(sel, cur_b);
    rx_sample_stb = capture_of(sel, cur_b);
    tx_fclk_o     = cfg_master ? g_tx_f : e_tx_f;
    tx_frame_stb  = cfg_master ? g_tx_s : e_tx_s;
    own_rx_f      = cfg_master ? g_rx_f : e_rx_f;
    own_rx_s      = cfg_master ? g_rx_s : e_rx_s;
    rx_fclk_o     = cfg_rx_share ? tx_fclk_o : own_rx_f;
    rx_frame_stb  = cfg_rx_share ? tx_frame_stb : own_rx_s;
  end

  // R2: launch and capture strobes never coincide
  p_launch_capture_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_shift_stb && rx_sample_stb));
  // R3: with a steady mode, a launch strobe sits on a bit-clock change
  p_launch_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cfg_master) && tx_shift_stb) |-> (bclk_o != $past(bclk_o)));
  // R5: in steady master mode the transmit frame strobe follows a launch strobe
  p_frame_after_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && $stable(cfg_launch_rise) && tx_frame_stb)
      |-> $past(tx_shift_stb));

endmodule

// File: tb/aud_sclk_gen_test.sv
`timescale 1ns/1ps
module aud_sclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b1;
  logic       cfg_launch_rise = 1'b0;
  logic [7:0] cfg_bdiv = 8'd3;
  logic [8:0] cfg_tx_len = 9'd63;
  logic [8:0] cfg_rx_len = 9'd31;
  logic       cfg_rx_share = 1'b0;
  logic       ext_bclk = 1'b0;
  logic       ext_tx_fclk = 1'b0;
  logic       ext_rx_fclk = 1'b0;
  logic       bclk_o, tx_fclk_o, rx_fclk_o;
  logic       tx_shift_stb, tx_frame_stb, rx_sample_stb, rx_frame_stb;

  int errs = 0;
  int checks = 0;
  int exp_q[$];
  bit sb_on = 1'b0;

  always #2.5 clk = ~clk;

  aud_sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .cfg_launch_rise(cfg_launch_rise), .cfg_bdiv(cfg_bdiv),
    .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len),
    .cfg_rx_share(cfg_rx_share), .ext_bclk(ext_bclk),
    .ext_tx_fclk(ext_tx_fclk), .ext_rx_fclk(ext_rx_fclk),
    .bclk_o(bclk_o), .tx_fclk_o(tx_fclk_o), .rx_fclk_o(rx_fclk_o),
    .tx_shift_stb(tx_shift_stb), .tx_frame_stb(tx_frame_stb),
    .rx_sample_stb(rx_sample_stb), .rx_frame_stb(rx_frame_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frame(input bit rx);
    do @(negedge clk); while (!(rx ? rx_frame_stb : tx_frame_stb));
  endtask

  // Called in a frame-strobe cycle: counts launches up to the next strobe.
  task automatic count_frame(input bit rx, output int bits, output int lows);
    bits = 0; lows = 0;
    forever begin
      @(negedge clk);
      if (tx_shift_stb) begin
        bits++;
        if (!(rx ? rx_fclk_o : tx_fclk_o)) lows++;
      end
      if (rx ? rx_frame_stb : tx_frame_stb) break;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    while (bclk_o !== 1'b0) @(negedge clk);
    while (bclk_o !== 1'b1) @(negedge clk);
    hi = 0;
    while (bclk_o === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (bclk_o === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic strobe_scan(input int n, input bit pol, input string tag);
    int bad = 0, shifts = 0;
    bit pb = bclk_o, pf = tx_fclk_o, ps = tx_shift_stb;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_shift_stb) begin
        shifts++;
        if (pol ? !(bclk_o && !pb) : !(!bclk_o && pb)) bad++;
        if (ps) bad++;
      end
      if (rx_sample_stb && (pol ? !(!bclk_o && pb) : !(bclk_o && !pb))) bad++;
      if (tx_frame_stb && !(ps && !tx_fclk_o && pf)) bad++;
      pb = bclk_o; pf = tx_fclk_o; ps = tx_shift_stb;
    end
    chk(bad == 0, {tag, " strobe edges (R2 R3 R5)"}, bad, 0);
    chk(shifts > 0, {tag, " launches seen R2"}, shifts, 1);
  endtask

  // Scoreboard monitor: compares each rise-to-rise period with the queue.
  initial begin
    bit prevb = 1'b0, started = 1'b0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (sb_on) begin
        cnt++;
        if (bclk_o && !prevb) begin
          if (started && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            chk(cnt == e, "R1 scoreboard bit period", cnt, e);
          end
          started = 1'b1;
          cnt = 0;
        end
      end else begin
        started = 1'b0;
        cnt = 0;
      end
      prevb = bclk_o;
    end
  end

  task automatic sb_run(input int ratio, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(ratio);
    sb_on = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    sb_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int hi, lo, bits, lows;
    int hb[400], htf[400], hrf[400];
    int bad_b, bad_f, bad_r, bad_s, bad_fs;

    // R11 reset state
    tick(4);
    chk(bclk_o == 0 && tx_fclk_o == 0 && rx_fclk_o == 0, "R11 clocks in reset", bclk_o, 0);
    chk({tx_shift_stb, tx_frame_stb, rx_sample_stb, rx_frame_stb} == 4'b0,
        "R11 strobes in reset", {tx_shift_stb, tx_frame_stb, rx_sample_stb, rx_frame_stb}, 0);
    rst_n = 1'b1;
    wait_frame(0); wait_frame(0); wait_frame(0);

    // R1 even ratio 4
    measure(hi, lo);
    chk(hi == 2, "R1 high time ratio 4", hi, 2);
    chk(lo == 2, "R1 low time ratio 4", lo, 2);
    sb_run(4, 8);
    strobe_scan(600, 1'b0, "falling launch");

    // R4 transmit frame, R6 receive frame
    wait_frame(0); count_frame(0, bits, lows);
    chk(bits == 64, "R4 tx frame length", bits, 64);
    chk(lows == 32, "R4 tx left slot", lows, 32);
    wait_frame(1); count_frame(1, bits, lows);
    chk(bits == 32, "R6 rx frame length", bits, 32);
    chk(lows == 16, "R6 rx left slot", lows, 16);

    // R1 odd ratio 5
    cfg_bdiv = 8'd4;
    wait_frame(0); wait_frame(0);
    measure(hi, lo);
    chk(hi == 3, "R1 high time ratio 5", hi, 3);
    chk(lo == 2, "R1 low time ratio 5", lo, 2);
    sb_run(5, 6);

    // R9 divider change mid-frame
    wait_frame(0); tick(20);
    cfg_bdiv = 8'd5;
    measure(hi, lo);
    chk(hi == 3 && lo == 2, "R9 old ratio before boundary", hi + lo, 5);
    wait_frame(0);
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R9 new ratio after boundary", hi + lo, 6);

    // R8 frame length change mid-frame
    wait_frame(0);
    cfg_tx_len = 9'd15;
    count_frame(0, bits, lows);
    chk(bits == 64, "R8 running frame keeps old length", bits, 64);
    count_frame(0, bits, lows);
    chk(bits == 16, "R8 next frame uses new length", bits, 16);
    chk(lows == 8, "R8 new left slot", lows, 8);

    // R2 rising launch
    cfg_launch_rise = 1'b1;
    tick(40);
    strobe_scan(600, 1'b1, "rising launch");

    // R7 shared frame clock
    cfg_rx_share = 1'b1;
    bad_s = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rx_fclk_o != tx_fclk_o || rx_frame_stb != tx_frame_stb) bad_s++;
    end
    chk(bad_s == 0, "R7 rx follows tx when shared", bad_s, 0);
    cfg_rx_share = 1'b0;
    cfg_launch_rise = 1'b0;

    // R10 slave mode
    cfg_master = 1'b0;
    bad_b = 0; bad_f = 0; bad_r = 0; bad_fs = 0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        if (bclk_o != hb[n-2][0]) bad_b++;
        if (tx_fclk_o != htf[n-2][0]) bad_f++;
        if (rx_fclk_o != hrf[n-2][0]) bad_r++;
        if (tx_shift_stb != (hb[n-2] == 0 && hb[n-3] == 1)) bad_fs++;
        if (rx_sample_stb != (hb[n-2] == 1 && hb[n-3] == 0)) bad_fs++;
        if (tx_frame_stb != (htf[n-2] == 0 && htf[n-3] == 1)) bad_fs++;
        if (rx_frame_stb != (hrf[n-2] == 0 && hrf[n-3] == 1)) bad_fs++;
      end
      hb[n]  = ((n + 2) / 4) % 2;
      htf[n] = ((n + 2) / 64) % 2;
      hrf[n] = ((n + 2) / 48) % 2;
      ext_bclk = hb[n][0]; ext_tx_fclk = htf[n][0]; ext_rx_fclk = hrf[n][0];
    end
    chk(bad_b == 0, "R10 bit clock follows external", bad_b, 0);
    chk(bad_f == 0, "R10 tx frame follows external", bad_f, 0);
    chk(bad_r == 0, "R10 rx frame follows external", bad_r, 0);
    chk(bad_fs == 0, "R10 strobes from external edges", bad_fs, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule